// File: doc/BRIEF.md
# Full-Duplex Packet DMA Engine

This block carries packet data between a network MAC and a shared packet memory, one 32-bit doubleword per memory access. In the transmit direction it reads doublewords from memory and pushes them into the MAC transmit FIFO. In the receive direction it pops doublewords from the MAC receive FIFO and writes them to memory. Each direction has its own address and word counter, so a transmit job and a receive job can be in progress at the same time.

Software or a packet manager starts a direction with a one-cycle strobe that carries a start address and a doubleword count. The engine then raises requests to a memory arbiter that shares its clock. It holds each request until the arbiter acknowledges it, and only one request is ever outstanding. When both directions are ready in the same slot, a one-bit toggle hands the slot to the direction that was not served last, so a busy direction cannot starve the other. Each direction raises a done flag once its count has been used up.

Top module: `pkt_dma_engine`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mem_req`, `tx_fifo_push`, `rx_fifo_pop`, `tx_done` and `rx_done` are all 0.
- R2: A transmit request (`mem_we`=0) is raised only when `tx_fifo_free` was at least 2 (two 16-bit entries, one doubleword) in the cycle before it rose, and transmit words remain.
- R3: A receive request (`mem_we`=1) is raised only when `rx_fifo_level` is at least 2. It pulses `rx_fifo_pop` for one cycle and carries the FIFO head word (`rx_fifo_rdata` in the pop cycle) as `mem_wdata`.
- R4: Each direction's accesses use addresses start, start+4, start+8 and so on, counted independently of the other direction.
- R5: `done` of a direction rises once all of its words have been acknowledged. A start with a count of 0 sets it in the next cycle. A start with a nonzero count clears it in the next cycle.
- R6: When both directions are ready in the same free slot, the slot goes to the direction not served last. After reset, transmit wins the first tie.
- R7: While `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. The request drops in the cycle after the acknowledge.
- R8: In the acknowledge cycle of a transmit access, `tx_fifo_push` is 1 for one cycle and `tx_fifo_wdata` equals `mem_rdata`.
- R9: A start strobe for a direction that still has words remaining is ignored.
- R10: Each direction performs exactly its programmed number of accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock shared with the arbiter |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Load strobe for the transmit counter |
| tx_start_addr | input | ADDR_W | Transmit start byte address |
| tx_start_cnt | input | CNT_W | Transmit doubleword count |
| tx_done | output | 1 | Transmit count used up |
| rx_start | input | 1 | Load strobe for the receive counter |
| rx_start_addr | input | ADDR_W | Receive start byte address |
| rx_start_cnt | input | CNT_W | Receive doubleword count |
| rx_done | output | 1 | Receive count used up |
| tx_fifo_free | input | LVL_W | Free 16-bit entries in the transmit FIFO |
| tx_fifo_push | output | 1 | Write strobe into the transmit FIFO |
| tx_fifo_wdata | output | DATA_W | Doubleword into the transmit FIFO |
| rx_fifo_level | input | LVL_W | Filled 16-bit entries in the receive FIFO |
| rx_fifo_rdata | input | DATA_W | Head doubleword of the receive FIFO |
| rx_fifo_pop | output | 1 | Read strobe from the receive FIFO |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (receive), 0 = read (transmit) |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write doubleword |
| mem_rdata | input | DATA_W | Read doubleword, valid with `mem_ack` |
| mem_ack | input | 1 | Arbiter acknowledge |

## Verification
The bench targets the slot sharing first. With both directions ready, a design whose toggle is wrong would serve one direction back to back or start with receive, and the logged order of directions would not match the expected interleave. A FIFO holding only one entry must block its direction: a design that tests for a nonzero level instead of a full doubleword would issue accesses and push or pop half-empty words. The bench also holds the acknowledge off, restarts a busy channel and programs zero counts. These catch a design that drifts its address while waiting, reloads a counter mid-packet, or never raises done for an empty job.

// File: rtl/dma_pkg.sv
// Shared types for the packet DMA engine.
package dma_pkg;
    // Direction served by a memory slot.
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dma_dir_e;

    // Number of directions handled by the engine.
    localparam int NUM_DIRS = 2;
endpackage

// File: rtl/dma_chan.sv
// Per-direction address and word counter.
// Loads start address and count on a strobe while idle, steps the address
// by one doubleword per acknowledged access, and flags completion.
// Assumes step only arrives while words remain.
module dma_chan #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic              done
);
    logic [CNT_W-1:0] remain;

    // Counter load, step and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
            done   <= 1'b0;
        end else if (start && remain == '0) begin
            addr   <= start_addr;
            remain <= start_cnt;
            done   <= (start_cnt == '0);
        end else if (step && remain != '0) begin
            addr   <= addr + ADDR_W'(STEP);
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
                done <= 1'b1;
            end
        end
    end

    // Words remain in the current job.
    assign active = (remain != '0);

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);  // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active && !step) |=> $stable(addr));  // R9
endmodule

// File: rtl/dma_slot_pick.sv
// Chooses which direction takes a free memory slot.
// When both are ready it serves the direction not served last; after reset
// the receive side counts as served last so transmit wins the first tie.
module dma_slot_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_free,
    input  logic tx_want,
    input  logic rx_want,
    output logic grant_tx,
    output logic grant_rx
);
    logic last_rx;

    // Slot decision from readiness and last served direction.
    always_comb begin
        grant_tx = 1'b0;
        grant_rx = 1'b0;
        if (slot_free) begin
            if (tx_want && rx_want) begin
                grant_tx = last_rx;
                grant_rx = !last_rx;
            end else begin
                grant_tx = tx_want;
                grant_rx = rx_want;
            end
        end
    end

    // Remember the direction served by the latest grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rx <= 1'b1;
        end else if (grant_tx) begin
            last_rx <= 1'b0;
        end else if (grant_rx) begin
            last_rx <= 1'b1;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_tx, grant_rx}));  // R6
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_tx && rx_want) |=> !(slot_free && tx_want && rx_want && grant_tx));  // R6
endmodule

// File: rtl/pkt_dma_engine.sv
// Full-duplex packet DMA engine top.
// Moves doublewords between the MAC FIFOs and packet memory through a
// request/acknowledge arbiter port, one outstanding access at a time.
// Assumes the FIFO levels count ENTRY_W-bit entries and that the receive
// FIFO presents its head word on rx_fifo_rdata.
module pkt_dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int LVL_W   = 5,
    parameter int DATA_W  = 32,
    parameter int ENTRY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [ADDR_W-1:0] tx_start_addr,
    input  logic [CNT_W-1:0]  tx_start_cnt,
    output logic              tx_done,
    input  logic              rx_start,
    input  logic [ADDR_W-1:0] rx_start_addr,
    input  logic [CNT_W-1:0]  rx_start_cnt,
    output logic              rx_done,
    input  logic [LVL_W-1:0]  tx_fifo_free,
    output logic              tx_fifo_push,
    output logic [DATA_W-1:0] tx_fifo_wdata,
    input  logic [LVL_W-1:0]  rx_fifo_level,
    input  logic [DATA_W-1:0] rx_fifo_rdata,
    output logic              rx_fifo_pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int ENTRIES_PER_WORD = DATA_W / ENTRY_W;
    localparam int BYTES_PER_WORD   = DATA_W / 8;
    localparam logic [LVL_W-1:0] WORD_ENTRIES = LVL_W'(ENTRIES_PER_WORD);

    logic              req_q;
    dma_dir_e          dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic [NUM_DIRS-1:0] chan_start;
    logic [NUM_DIRS-1:0] chan_step;
    logic [NUM_DIRS-1:0] chan_active;
    logic [NUM_DIRS-1:0] chan_done;
    logic [ADDR_W-1:0]   chan_start_addr [NUM_DIRS];
    logic [CNT_W-1:0]    chan_start_cnt  [NUM_DIRS];
    logic [ADDR_W-1:0]   chan_addr       [NUM_DIRS];

    logic tx_want, rx_want, grant_tx, grant_rx, ack_seen;

    // Route per-direction start fields into indexed arrays.
    always_comb begin
        chan_start[DIR_TX]      = tx_start;
        chan_start[DIR_RX]      = rx_start;
        chan_start_addr[DIR_TX] = tx_start_addr;
        chan_start_addr[DIR_RX] = rx_start_addr;
        chan_start_cnt[DIR_TX]  = tx_start_cnt;
        chan_start_cnt[DIR_RX]  = rx_start_cnt;
    end

    // Acknowledge of the outstanding access steps its own counter.
    assign ack_seen          = req_q && mem_ack;
    assign chan_step[DIR_TX] = ack_seen && (dir_q == DIR_TX);
    assign chan_step[DIR_RX] = ack_seen && (dir_q == DIR_RX);

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_chan
        dma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .STEP   (BYTES_PER_WORD)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (chan_start[d]),
            .start_addr (chan_start_addr[d]),
            .start_cnt  (chan_start_cnt[d]),
            .step       (chan_step[d]),
            .addr       (chan_addr[d]),
            .active     (chan_active[d]),
            .done       (chan_done[d])
        );
    end

    // Readiness: words remain and the FIFO can take or give a doubleword.
    assign tx_want = chan_active[DIR_TX] && (tx_fifo_free  >= WORD_ENTRIES);
    assign rx_want = chan_active[DIR_RX] && (rx_fifo_level >= WORD_ENTRIES);

    dma_slot_pick u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_free (!req_q),
        .tx_want   (tx_want),
        .rx_want   (rx_want),
        .grant_tx  (grant_tx),
        .grant_rx  (grant_rx)
    );

    // Request register: issue on a grant, hold until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            dir_q   <= DIR_TX;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (ack_seen) begin
            req_q <= 1'b0;
        end else if (grant_tx) begin
            req_q  <= 1'b1;
            dir_q  <= DIR_TX;
            addr_q <= chan_addr[DIR_TX];
        end else if (grant_rx) begin
            req_q   <= 1'b1;
            dir_q   <= DIR_RX;
            addr_q  <= chan_addr[DIR_RX];
            wdata_q <= rx_fifo_rdata;
        end
    end

    assign mem_req       = req_q;
    assign mem_we        = (dir_q == DIR_RX);
    assign mem_addr      = addr_q;
    assign mem_wdata     = wdata_q;
    assign rx_fifo_pop   = grant_rx;
    assign tx_fifo_push  = chan_step[DIR_TX];
    assign tx_fifo_wdata = mem_rdata;
    assign tx_done       = chan_done[DIR_TX];
    assign rx_done       = chan_done[DIR_RX];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R7
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);  // R7
    AST_TX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> ($past(tx_fifo_free) >= WORD_ENTRIES));  // R2
    AST_RX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_pop |-> (rx_fifo_level >= WORD_ENTRIES));  // R3
    AST_POP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_pop |=> (mem_req && mem_we && mem_wdata == $past(rx_fifo_rdata)));  // R3
    AST_PUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_push |=> !tx_fifo_push);  // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_done && !rx_done));  // R1
endmodule

// File: tb/pkt_dma_engine_test.sv
module pkt_dma_engine_test;
    localparam int CLK_PERIOD = 20;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int LW = 5;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] ta;
        logic [CW-1:0] tc;
        logic [AW-1:0] ra;
        logic [CW-1:0] rc;
        logic [LW-1:0] tf;
        logic [LW-1:0] rl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ta:16'h0100, tc:8'd3, ra:16'h0800, rc:8'd2, tf:5'd8, rl:5'd8},
        '{ta:16'h0200, tc:8'd2, ra:16'h0900, rc:8'd0, tf:5'd8, rl:5'd8},
        '{ta:16'h0300, tc:8'd3, ra:16'h0A00, rc:8'd3, tf:5'd1, rl:5'd8},
        '{ta:16'h0400, tc:8'd2, ra:16'h0B00, rc:8'd2, tf:5'd8, rl:5'd1},
        '{ta:16'h0500, tc:8'd0, ra:16'h0C00, rc:8'd4, tf:5'd2, rl:5'd2},
        '{ta:16'h0600, tc:8'd4, ra:16'h0D00, rc:8'd1, tf:5'd3, rl:5'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 1'b0, rx_start = 1'b0;
    logic [AW-1:0] tx_start_addr = '0, rx_start_addr = '0;
    logic [CW-1:0] tx_start_cnt = '0, rx_start_cnt = '0;
    logic tx_done, rx_done, tx_fifo_push, rx_fifo_pop;
    logic [LW-1:0] tx_fifo_free = '0, rx_fifo_level = '0;
    logic [DW-1:0] tx_fifo_wdata, rx_fifo_rdata, mem_wdata, mem_rdata;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic hold_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // Memory-side and FIFO-side models, written only here.
    int rx_idx = 0;
    logic pop_seen = 1'b0;
    int log_n = 0;
    logic log_we [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_wdata [64];
    int push_n = 0;
    logic [DW-1:0] push_data [64];

    assign rx_fifo_rdata = 32'hA000_0000 + DW'(rx_idx);
    assign mem_rdata = {16'hC0DE, mem_addr};

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_dma_engine uut (
        .clk(clk), .rst_n(rst_n),
        .tx_start(tx_start), .tx_start_addr(tx_start_addr), .tx_start_cnt(tx_start_cnt), .tx_done(tx_done),
        .rx_start(rx_start), .rx_start_addr(rx_start_addr), .rx_start_cnt(rx_start_cnt), .rx_done(rx_done),
        .tx_fifo_free(tx_fifo_free), .tx_fifo_push(tx_fifo_push), .tx_fifo_wdata(tx_fifo_wdata),
        .rx_fifo_level(rx_fifo_level), .rx_fifo_rdata(rx_fifo_rdata), .rx_fifo_pop(rx_fifo_pop),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always @(negedge clk) begin
        if (pop_seen) rx_idx = rx_idx + 1;
        pop_seen = rx_fifo_pop;
        if (mem_req && !mem_ack && !hold_ack && log_n < 64) begin
            log_we[log_n] = mem_we;
            log_addr[log_n] = mem_addr;
            log_wdata[log_n] = mem_wdata;
            log_n = log_n + 1;
        end
        mem_ack = mem_req && !mem_ack && !hold_ack;
        #1;
        if (tx_fifo_push && push_n < 64) begin
            push_data[push_n] = tx_fifo_wdata;
            push_n = push_n + 1;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lb, pb, rb, et, er, rt, rr, ti, ri;
        logic last_rx;
        logic exp_dir [16];
        tick(1);
        // R1: reset state, including the cycle right after release.
        rst_n = 1'b0;
        tick(2);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 done", {30'd0, tx_done, rx_done}, 32'd0);
        rst_n = 1'b1;
        tx_fifo_free = 5'd8;
        rx_fifo_level = 5'd8;
        tick(1);
        chk("R1 strobes", {29'd0, mem_req, tx_fifo_push, rx_fifo_pop}, 32'd0);

        // Table walk: R2 R3 R4 R6 R8 R10 and done flags R5.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            tx_fifo_free = VECS[v].tf;
            rx_fifo_level = VECS[v].rl;
            tick(2);
            lb = log_n; pb = push_n; rb = rx_idx;
            et = (VECS[v].tf >= 2) ? int'(VECS[v].tc) : 0;
            er = (VECS[v].rl >= 2) ? int'(VECS[v].rc) : 0;
            rt = et; rr = er; last_rx = 1'b1;
            for (int k = 0; k < et + er; k++) begin
                if (rt > 0 && rr > 0) exp_dir[k] = !last_rx;
                else exp_dir[k] = (rr > 0);
                last_rx = exp_dir[k];
                if (exp_dir[k]) rr--; else rt--;
            end
            tx_start_addr = VECS[v].ta; tx_start_cnt = VECS[v].tc;
            rx_start_addr = VECS[v].ra; rx_start_cnt = VECS[v].rc;
            tx_start = 1'b1; rx_start = 1'b1;
            tick(1);
            tx_start = 1'b0; rx_start = 1'b0;
            tick(60);
            chk("R10 access count", DW'(log_n - lb), DW'(et + er));
            chk("R8 push count", DW'(push_n - pb), DW'(et));
            ti = 0; ri = 0;
            for (int k = 0; k < et + er && k < 16; k++) begin
                chk("R6 slot order", {31'd0, log_we[lb+k]}, {31'd0, exp_dir[k]});
                if (log_we[lb+k]) begin
                    chk("R4 rx addr", {16'd0, log_addr[lb+k]}, {16'd0, VECS[v].ra + AW'(4*ri)});
                    chk("R3 rx data", log_wdata[lb+k], 32'hA000_0000 + DW'(rb + ri));
                    ri++;
                end else begin
                    chk("R4 tx addr", {16'd0, log_addr[lb+k]}, {16'd0, VECS[v].ta + AW'(4*ti)});
                    ti++;
                end
            end
            for (int k = 0; k < et; k++)
                chk("R8 push data", push_data[pb+k], {16'hC0DE, VECS[v].ta + AW'(4*k)});
            chk("R2 tx done", {31'd0, tx_done}, {31'd0, (VECS[v].tc == 0) || (VECS[v].tf >= 2)});
            chk("R3 rx done", {31'd0, rx_done}, {31'd0, (VECS[v].rc == 0) || (VECS[v].rl >= 2)});
        end

        // R5: zero-count start sets done in the next cycle without access.
        do_reset();
        lb = log_n;
        tx_start_addr = 16'h0700; tx_start_cnt = 8'd0; tx_start = 1'b1;
        tick(1);
        tx_start = 1'b0;
        chk("R5 zero count done", {31'd0, tx_done}, 32'd1);
        tick(5);
        chk("R5 zero count no access", DW'(log_n - lb), 32'd0);

        // R7: request held stable while acknowledge is withheld.
        do_reset();
        tx_fifo_free = 5'd8;
        hold_ack = 1'b1;
        pb = push_n;
        tx_start_addr = 16'h0400; tx_start_cnt = 8'd3; tx_start = 1'b1;
        tick(1);
        tx_start = 1'b0;
        tick(2);
        chk("R7 req up", {31'd0, mem_req}, 32'd1);
        chk("R7 addr", {16'd0, mem_addr}, 32'h0400);
        tick(4);
        chk("R7 req held", {31'd0, mem_req}, 32'd1);
        chk("R7 addr held", {16'd0, mem_addr}, 32'h0400);
        chk("R7 we held", {31'd0, mem_we}, 32'd0);
        // R9: restart while words remain is ignored.
        tx_start_addr = 16'h0F00; tx_start_cnt = 8'd1; tx_start = 1'b1;
        tick(1);
        tx_start = 1'b0;
        hold_ack = 1'b0;
        tick(30);
        chk("R9 words kept", DW'(push_n - pb), 32'd3);
        for (int k = 0; k < 3; k++)
            chk("R9 addr kept", push_data[pb+k], {16'hC0DE, 16'h0400 + AW'(4*k)});
        chk("R5 done after job", {31'd0, tx_done}, 32'd1);
        chk("R7 idle after", {31'd0, mem_req}, 32'd0);

        // R5: nonzero start clears done next cycle, then sets it again.
        tx_start_addr = 16'h0700; tx_start_cnt = 8'd1; tx_start = 1'b1;
        tick(1);
        tx_start = 1'b0;
        chk("R5 done cleared", {31'd0, tx_done}, 32'd0);
        tick(10);
        chk("R5 done set", {31'd0, tx_done}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule